// File: doc/BRIEF.md
# SPI FIFO Status, Event and Interrupt Unit

This block sits beside the transmit and receive byte FIFOs of a SPI master and turns their activity into software-visible status. It follows one-byte push and pop strobes on each FIFO to keep a fill count, compares each count against a programmable threshold, and latches four event flags: receive data available, transmit space available, receive overflow and transmit overflow. Software clears a flag by writing a one to its bit. A mask register with the same bit layout picks which flags drive a single interrupt line.

A receive flag can also be raised below the threshold. When the shift engine signals the end of a transaction, any bytes still held in the receive FIFO raise the receive flag. This stops the final few bytes of a transfer from being stranded under the threshold. Each flag is a two-state machine, FLAG_IDLE and FLAG_PENDING. It moves IDLE to PENDING when its set condition holds and no clear is written in that cycle. It moves PENDING to IDLE on a write-one-to-clear. The interrupt line is a two-state machine, IRQ_QUIET and IRQ_RAISED. It moves QUIET to RAISED when any unmasked flag is pending, and RAISED to QUIET when none is.

Top module: `spi_fifo_evt`

## Requirements
- R1: The event word shows the receive byte count in bits 29:24 and the transmit byte count in bits 21:16. A push adds one, a pop removes one, a push together with a pop leaves the count unchanged, and a pop on an empty FIFO is ignored.
- R2: A count never exceeds DEPTH (32). A push without a pop on a full FIFO leaves the count at DEPTH and sets the overflow flag: bit 11 for receive, bit 10 for transmit.
- R3: The receive-available flag (bit 9) becomes pending one cycle after the receive count is strictly greater than the receive threshold. At a count equal to the threshold it stays clear.
- R4: After an end-of-transaction strobe, a nonzero receive count sets bit 9 even when the count is below the threshold. This tail condition lapses once the receive count has reached zero.
- R5: The transmit-space flag (bit 8) becomes pending one cycle after the transmit count is at or below the transmit threshold. Above the threshold it stays clear.
- R6: A write to the event register clears, on that clock edge, every flag whose data bit is 1. Flags written with 0 are kept. Writing all ones clears all four flags. Event writes never change the count fields.
- R7: If a flag's condition still holds when the flag is cleared, the flag is pending again on the following cycle.
- R8: The mode register holds the transmit threshold in bits 13:8 and the receive threshold in bits 5:0. After reset they are 4 and 3.
- R9: The mask register enables the interrupt for each flag at the flag's own bit position (11:8). `irq` is high exactly one cycle after some pending flag has its mask bit set.
- R10: While reset is asserted, the event word, the mask and `irq` are all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_push | input | 1 | One byte written into the transmit FIFO |
| tx_pop | input | 1 | One byte taken from the transmit FIFO by the shift engine |
| rx_push | input | 1 | One byte written into the receive FIFO by the shift engine |
| rx_pop | input | 1 | One byte read from the receive FIFO |
| xfer_end | input | 1 | Pulse at the end of a transaction |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select: 0 mode, 1 event, 2 mask |
| reg_wdata | input | 32 | Register write data |
| event_word | output | 32 | Counts and event flags |
| irq | output | 1 | Interrupt request |

## Verification
The assertions assume that the push and pop strobes report real FIFO traffic, that the counts change only through these strobes, and that select value 3 is never written. The stimulus drives one strobe per FIFO per cycle and uses only the three defined selects. It pops no more bytes than it has pushed, except for one deliberate pop on an empty FIFO. Overflow is reached by pushing one byte past DEPTH without a matching pop.

// File: rtl/spi_evt_pkg.sv
package spi_evt_pkg;
    typedef enum logic [1:0] {
        SEL_MODE  = 2'd0,
        SEL_EVENT = 2'd1,
        SEL_MASK  = 2'd2
    } reg_sel_e;

    typedef enum logic {
        FLAG_IDLE    = 1'b0,
        FLAG_PENDING = 1'b1
    } flag_state_e;

    typedef enum logic {
        IRQ_QUIET  = 1'b0,
        IRQ_RAISED = 1'b1
    } irq_state_e;

    // flag order inside the 4-bit flag vector; bit position = FLAG_LSB + index
    localparam int FLAG_LSB   = 8;
    localparam int NUM_FLAGS  = 4;
    localparam int IDX_TXNF   = 0;
    localparam int IDX_RXAV   = 1;
    localparam int IDX_TXOVF  = 2;
    localparam int IDX_RXOVF  = 3;

    localparam int FIELD_W    = 6;   // width of count and threshold fields
    localparam int RXCNT_LSB  = 24;
    localparam int TXCNT_LSB  = 16;
    localparam int TXTHR_LSB  = 8;
    localparam int RXTHR_LSB  = 0;
    localparam int TXTHR_RST  = 4;
    localparam int RXTHR_RST  = 3;
endpackage

// File: rtl/fifo_level.sv
module fifo_level #(
    parameter int DEPTH = 32,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic             pop,
    output logic [CNT_W-1:0] cnt,
    output logic             ovf
);
    localparam logic [CNT_W-1:0] FULL = CNT_W'(DEPTH);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else begin
            unique case ({push, pop})
                2'b10:   if (cnt != FULL) cnt <= cnt + 1'b1;
                2'b01:   if (cnt != '0)   cnt <= cnt - 1'b1;
                default: cnt <= cnt;
            endcase
        end
    end

    assign ovf = push & ~pop & (cnt == FULL);

    a_r2_cap: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= FULL);
    a_r1_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (push && pop) |=> $stable(cnt));
    a_r2_full_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !pop && cnt == FULL) |=> (cnt == FULL));
endmodule

// File: rtl/evt_flag.sv
module evt_flag
    import spi_evt_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic pend_o
);
    flag_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FLAG_IDLE:    if (set_i && !clr_i) state_d = FLAG_PENDING;
            FLAG_PENDING: if (clr_i)           state_d = FLAG_IDLE;
            default:      state_d = FLAG_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= FLAG_IDLE;
        else        state_q <= state_d;
    end

    always_comb pend_o = (state_q == FLAG_PENDING);

    a_r6_clear: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> !pend_o);
    a_r7_reassert: assert property (@(posedge clk) disable iff (!rst_n)
        (set_i && !clr_i) |=> pend_o);
endmodule

// File: rtl/irq_ctl.sv
module irq_ctl
    import spi_evt_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic any_i,
    output logic irq_o
);
    irq_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            IRQ_QUIET:  if (any_i)  state_d = IRQ_RAISED;
            IRQ_RAISED: if (!any_i) state_d = IRQ_QUIET;
            default:    state_d = IRQ_QUIET;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= IRQ_QUIET;
        else        state_q <= state_d;
    end

    always_comb irq_o = (state_q == IRQ_RAISED);
endmodule

// File: rtl/spi_fifo_evt.sv
module spi_fifo_evt
    import spi_evt_pkg::*;
#(
    parameter int DEPTH = 32
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        tx_push,
    input  logic        tx_pop,
    input  logic        rx_push,
    input  logic        rx_pop,
    input  logic        xfer_end,
    input  logic        reg_wr,
    input  logic [1:0]  reg_sel,
    input  logic [31:0] reg_wdata,
    output logic [31:0] event_word,
    output logic        irq
);
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam int CMP_W = (CNT_W > FIELD_W) ? CNT_W : FIELD_W;

    logic [CNT_W-1:0]     tx_cnt, rx_cnt;
    logic                 tx_ovf, rx_ovf;
    logic [FIELD_W-1:0]   tx_thr_q, rx_thr_q;
    logic [NUM_FLAGS-1:0] mask_q, flag_set, flag_clr, flag_pend;
    logic                 tail_q;
    logic                 wr_mode, wr_event, wr_mask;
    logic                 unused_wdata;
    reg_sel_e             sel;

    assign unused_wdata = ^{reg_wdata[31:14], reg_wdata[7:6]};

    always_comb begin
        sel      = reg_sel_e'(reg_sel);
        wr_mode  = reg_wr && (sel == SEL_MODE);
        wr_event = reg_wr && (sel == SEL_EVENT);
        wr_mask  = reg_wr && (sel == SEL_MASK);
    end

    fifo_level #(.DEPTH(DEPTH)) u_tx_level (
        .clk(clk), .rst_n(rst_n), .push(tx_push), .pop(tx_pop),
        .cnt(tx_cnt), .ovf(tx_ovf)
    );

    fifo_level #(.DEPTH(DEPTH)) u_rx_level (
        .clk(clk), .rst_n(rst_n), .push(rx_push), .pop(rx_pop),
        .cnt(rx_cnt), .ovf(rx_ovf)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_thr_q <= FIELD_W'(TXTHR_RST);
            rx_thr_q <= FIELD_W'(RXTHR_RST);
            mask_q   <= '0;
            tail_q   <= 1'b0;
        end else begin
            if (wr_mode) begin
                tx_thr_q <= reg_wdata[TXTHR_LSB +: FIELD_W];
                rx_thr_q <= reg_wdata[RXTHR_LSB +: FIELD_W];
            end
            if (wr_mask) mask_q <= reg_wdata[FLAG_LSB +: NUM_FLAGS];
            tail_q <= xfer_end | (tail_q & (rx_cnt != '0));
        end
    end

    always_comb begin
        flag_set[IDX_TXNF]  = CMP_W'(tx_cnt) <= CMP_W'(tx_thr_q);
        flag_set[IDX_RXAV]  = (CMP_W'(rx_cnt) > CMP_W'(rx_thr_q))
                            | (tail_q & (rx_cnt != '0));
        flag_set[IDX_TXOVF] = tx_ovf;
        flag_set[IDX_RXOVF] = rx_ovf;
        flag_clr = wr_event ? reg_wdata[FLAG_LSB +: NUM_FLAGS] : '0;
    end

    for (genvar g = 0; g < NUM_FLAGS; g++) begin : g_flag
        evt_flag u_flag (
            .clk(clk), .rst_n(rst_n),
            .set_i(flag_set[g]), .clr_i(flag_clr[g]),
            .pend_o(flag_pend[g])
        );
    end

    irq_ctl u_irq (
        .clk(clk), .rst_n(rst_n),
        .any_i(|(flag_pend & mask_q)),
        .irq_o(irq)
    );

    always_comb begin
        event_word = '0;
        event_word[RXCNT_LSB +: FIELD_W]  = FIELD_W'(rx_cnt);
        event_word[TXCNT_LSB +: FIELD_W]  = FIELD_W'(tx_cnt);
        event_word[FLAG_LSB +: NUM_FLAGS] = flag_pend;
    end

    a_r3_rx_above: assert property (@(posedge clk) disable iff (!rst_n)
        ((CMP_W'(rx_cnt) > CMP_W'(rx_thr_q)) && !flag_clr[IDX_RXAV])
            |=> event_word[FLAG_LSB + IDX_RXAV]);
    a_r5_tx_room: assert property (@(posedge clk) disable iff (!rst_n)
        ((CMP_W'(tx_cnt) <= CMP_W'(tx_thr_q)) && !flag_clr[IDX_TXNF])
            |=> event_word[FLAG_LSB + IDX_TXNF]);
    a_r9_irq_on: assert property (@(posedge clk) disable iff (!rst_n)
        (|(flag_pend & mask_q)) |=> irq);
    a_r9_irq_off: assert property (@(posedge clk) disable iff (!rst_n)
        !(|(flag_pend & mask_q)) |=> !irq);
    a_r6_counts_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_event && !tx_push && !tx_pop) |=> $stable(tx_cnt));
endmodule

// File: tb/test_spi_fifo_evt.sv
module test_spi_fifo_evt;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tx_push = 0, tx_pop = 0, rx_push = 0, rx_pop = 0, xfer_end = 0;
    logic        reg_wr = 0;
    logic [1:0]  reg_sel = 0;
    logic [31:0] reg_wdata = 0;
    logic [31:0] event_word;
    logic        irq;
    int          n_run = 0;
    int          n_fail = 0;

    always #2 clk = ~clk;

    spi_fifo_evt i_spi_fifo_evt (
        .clk(clk), .rst_n(rst_n), .tx_push(tx_push), .tx_pop(tx_pop),
        .rx_push(rx_push), .rx_pop(rx_pop), .xfer_end(xfer_end),
        .reg_wr(reg_wr), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
        .event_word(event_word), .irq(irq)
    );

    task automatic tick();
        @(posedge clk); #1;
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] sel, input logic [31:0] d);
        reg_wr = 1; reg_sel = sel; reg_wdata = d; tick(); reg_wr = 0; reg_wdata = 0;
    endtask

    task automatic push_tx(input int n); tx_push = 1; repeat (n) tick(); tx_push = 0; endtask
    task automatic pop_tx(input int n);  tx_pop  = 1; repeat (n) tick(); tx_pop  = 0; endtask
    task automatic push_rx(input int n); rx_push = 1; repeat (n) tick(); rx_push = 0; endtask
    task automatic pop_rx(input int n);  rx_pop  = 1; repeat (n) tick(); rx_pop  = 0; endtask

    function automatic logic [5:0] rxc(); return event_word[29:24]; endfunction
    function automatic logic [5:0] txc(); return event_word[21:16]; endfunction

    task automatic t_reset();
        repeat (3) tick();
        chk("R10 event word in reset", event_word, 32'h0);
        chk("R10 irq in reset", {31'b0, irq}, 32'h0);
        rst_n = 1; tick();
        chk("R5 tx room after reset", {31'b0, event_word[8]}, 32'h1);
        chk("R1 counts zero", event_word[31:16], 16'h0);
    endtask

    task automatic t_tx_room();
        push_tx(4);
        chk("R1 tx count", {26'b0, txc()}, 32'd4);
        chk("R5 at threshold", {31'b0, event_word[8]}, 32'h1);
        wr(2'd1, 32'h0000_0100);
        chk("R6 cleared", {31'b0, event_word[8]}, 32'h0);
        tick();
        chk("R7 reasserted", {31'b0, event_word[8]}, 32'h1);
        wr(2'd1, 32'h0);
        chk("R6 zero write keeps", {31'b0, event_word[8]}, 32'h1);
        push_tx(1);
        wr(2'd1, 32'h0000_0100);
        tick();
        chk("R5 above threshold", {31'b0, event_word[8]}, 32'h0);
        tx_push = 1; tx_pop = 1; tick(); tx_push = 0; tx_pop = 0;
        chk("R1 push with pop", {26'b0, txc()}, 32'd5);
        pop_tx(2); tick();
        chk("R5 back below", {31'b0, event_word[8]}, 32'h1);
        pop_tx(3); pop_tx(1);
        chk("R1 pop on empty", {26'b0, txc()}, 32'd0);
    endtask

    task automatic t_rx_threshold();
        push_rx(3); tick();
        chk("R1 rx count", {26'b0, rxc()}, 32'd3);
        chk("R3 equal not set", {31'b0, event_word[9]}, 32'h0);
        push_rx(1); tick();
        chk("R3 above set", {31'b0, event_word[9]}, 32'h1);
        pop_rx(4); wr(2'd1, 32'h0000_0200); tick();
        chk("R3 cleared when empty", {31'b0, event_word[9]}, 32'h0);
    endtask

    task automatic t_rx_tail();
        push_rx(2); tick();
        chk("R4 below threshold", {31'b0, event_word[9]}, 32'h0);
        xfer_end = 1; tick(); xfer_end = 0; tick();
        chk("R4 tail sets", {31'b0, event_word[9]}, 32'h1);
        pop_rx(2); wr(2'd1, 32'h0000_0200);
        push_rx(1); tick();
        chk("R4 tail lapsed", {31'b0, event_word[9]}, 32'h0);
        pop_rx(1);
    endtask

    task automatic t_overflow();
        push_rx(32);
        chk("R2 rx full count", {26'b0, rxc()}, 32'd32);
        chk("R2 no ovf yet", {31'b0, event_word[11]}, 32'h0);
        push_rx(1);
        chk("R2 rx overflow", {31'b0, event_word[11]}, 32'h1);
        chk("R2 rx saturate", {26'b0, rxc()}, 32'd32);
        push_tx(33);
        chk("R2 tx overflow", {31'b0, event_word[10]}, 32'h1);
        chk("R2 tx saturate", {26'b0, txc()}, 32'd32);
        wr(2'd1, 32'hFFFF_FFFF);
        chk("R6 all cleared", {28'b0, event_word[11:8]}, 32'h0);
        chk("R6 counts kept", event_word[31:16], 16'h2020);
        tick();
        chk("R7 rx avail back", {31'b0, event_word[9]}, 32'h1);
        chk("R7 ovf stays clear", {31'b0, event_word[11]}, 32'h0);
        pop_rx(32); pop_tx(32);
        wr(2'd1, 32'hFFFF_FFFF); tick();
        chk("R5 idle flags", {28'b0, event_word[11:8]}, 32'h1);
    endtask

    task automatic t_mode();
        wr(2'd0, (32'd16 << 8) | 32'd1);
        push_rx(2); push_tx(10);
        wr(2'd1, 32'hFFFF_FFFF); tick();
        chk("R8 new thresholds", {30'b0, event_word[9:8]}, 32'h3);
        wr(2'd0, 32'h0000_0403);
        wr(2'd1, 32'hFFFF_FFFF); tick();
        chk("R8 default thresholds", {30'b0, event_word[9:8]}, 32'h0);
        pop_rx(2); pop_tx(10);
        wr(2'd1, 32'hFFFF_FFFF); tick();
        chk("R8 drained", {28'b0, event_word[11:8]}, 32'h1);
    endtask

    task automatic t_irq();
        chk("R9 unmasked quiet", {31'b0, irq}, 32'h0);
        wr(2'd2, 32'h0000_0200); tick();
        chk("R9 other bit masked", {31'b0, irq}, 32'h0);
        wr(2'd2, 32'h0000_0100);
        chk("R9 one cycle lag", {31'b0, irq}, 32'h0);
        tick();
        chk("R9 raised", {31'b0, irq}, 32'h1);
        wr(2'd1, 32'h0000_0100);
        chk("R9 still registered", {31'b0, irq}, 32'h1);
        tick();
        chk("R9 drops after clear", {31'b0, irq}, 32'h0);
        tick();
        chk("R9 rises on reassert", {31'b0, irq}, 32'h1);
        wr(2'd2, 32'h0); tick();
        chk("R9 mask off", {31'b0, irq}, 32'h0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        #1;
        t_reset();
        t_tx_room();
        t_rx_threshold();
        t_rx_tail();
        t_overflow();
        t_mode();
        t_irq();
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule